// File: doc/BRIEF.md
# Per-Resource Ownership Semaphore Array

This block holds one hardware mutex for each shared peripheral resource. Compartments use it to claim a resource for their exclusive use. Each semaphore has its own register in a small register window. A compartment writes 1 to the flag bit to claim the semaphore and writes 0 to give it back. The identity of the requester comes from the bus sideband and never from the write data. Software learns whether a claim succeeded by reading the register back, or from the response word of the write itself.

Claims are filtered by configuration that a neighbouring block supplies. For each resource there is a semaphore-mode enable and an 8-bit allow list, one bit per compartment ID. A claim succeeds only if the mode is on, the semaphore is free and the requester is on the list. A release succeeds only if it comes from the current holder. Turning the mode off forces the semaphore free. For each resource the block drives the taken state and the holder ID as plain outputs, and an access filter downstream uses them.

Register accesses arrive on a valid/ready request channel and leave on a valid/ready response channel that holds one entry. A request is accepted in a cycle where both `req_valid` and `req_ready` are high. `req_ready` is low only while a response is held and `rsp_ready` is low. A stalled response keeps its data stable until it is taken.

Top module: `semlock_array`

## Requirements
- R1: After reset every semaphore is free with holder ID 0, and no response is pending.
- R2: Semaphore n answers at byte address 0x104 + 8*n, for n below N_RES. In that word, bit 0 is the taken flag, bits 6:4 hold the holder ID, and all other bits read 0. A write to any other address changes no semaphore, and a read there returns 0.
- R3: A write with bit 0 = 1 to a free semaphore whose mode is on, coming from a requester whose bit is set in that resource's allow list, marks the semaphore taken with the holder set to the requester's sideband ID. The other write-data bits are ignored.
- R4: A claim is refused, and the semaphore stays free, when the requester's allow-list bit is clear or when the resource's semaphore mode is off.
- R5: A claim on a semaphore that is already taken leaves the taken flag and the holder unchanged, including when the claim comes from the holder itself.
- R6: A write with bit 0 = 0 frees the semaphore only when the requester's ID equals the holder. A release from any other ID leaves the taken flag and the holder unchanged.
- R7: While a resource's semaphore mode is off, its semaphore is free from the next clock edge on. If the mode goes off in the same cycle that a claim on that resource is accepted, the semaphore still ends up free.
- R8: Each accepted request yields exactly one response, one cycle later, carrying the semaphore word as it stands after the access (0 for addresses that are not mapped). `req_ready` is low only while a response is held with `rsp_ready` low. A held response keeps its data stable.
- R9: `sem_taken[n]` and `sem_owner[3n+2:3n]` show the state of semaphore n. The holder ID reads 0 whenever the semaphore is free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | DATA_W | Write data; only bit 0 is used |
| req_cid | input | 3 | Compartment ID of the requester (sideband) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response can be consumed |
| rsp_rdata | output | DATA_W | Semaphore word after the access |
| cfg_sem_en | input | N_RES | Semaphore mode enable for each resource |
| cfg_cid_allow | input | 8*N_RES | Allow list for each resource, 8 bits per resource |
| sem_taken | output | N_RES | Taken flag for each resource |
| sem_owner | output | 3*N_RES | Holder ID for each resource |

## Verification
The interaction that needs care is a forced release, where a resource's mode is turned off, landing in the same clock cycle as an accepted claim on that same resource. The bench provokes this by dropping the enable on the same falling edge that presents the claim. It expects the response word and the status outputs both to show the semaphore free, so the forced release wins over the claim. A second same-cycle case is a held response that stalls a new request. Here the bench checks that `req_ready` stays low and the held data does not move until `rsp_ready` returns.

// File: rtl/semlock_pkg.sv
package semlock_pkg;
  localparam int CID_W        = 3;
  localparam int NUM_CID      = 1 << CID_W;
  localparam int SEM_BASE     = 'h104;
  localparam int STRIDE_LOG2  = 3;
  localparam int FLAG_BIT     = 0;
  localparam int OWNER_LSB    = 4;
endpackage

// File: rtl/semlock_decode.sv
module semlock_decode
  import semlock_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int N_RES  = 16,
  parameter int IDX_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(SEM_BASE);
  localparam logic [ADDR_W-1:0] LIMIT  = ADDR_W'(N_RES);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] slot;

  assign off  = addr - BASE_A;
  assign slot = off >> STRIDE_LOG2;
  assign hit  = (addr >= BASE_A) && (off[STRIDE_LOG2-1:0] == '0) && (slot < LIMIT);
  assign idx  = slot[IDX_W-1:0];
endmodule

// File: rtl/semlock_cell.sv
module semlock_cell
  import semlock_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sem_en,
  input  logic [NUM_CID-1:0] allow,
  input  logic               wr_sel,
  input  logic               wr_bit,
  input  logic [CID_W-1:0]   cid,
  output logic               taken_q,
  output logic [CID_W-1:0]   owner_q,
  output logic               nxt_taken,
  output logic [CID_W-1:0]   nxt_owner
);
  logic claim_ok;
  logic release_ok;

  assign claim_ok   = wr_sel && wr_bit && !taken_q && allow[cid];
  assign release_ok = wr_sel && !wr_bit && taken_q && (owner_q == cid);

  always_comb begin
    nxt_taken = taken_q;
    nxt_owner = owner_q;
    if (!sem_en) begin
      nxt_taken = 1'b0;
      nxt_owner = '0;
    end else if (claim_ok) begin
      nxt_taken = 1'b1;
      nxt_owner = cid;
    end else if (release_ok) begin
      nxt_taken = 1'b0;
      nxt_owner = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
      owner_q <= '0;
    end else begin
      taken_q <= nxt_taken;
      owner_q <= nxt_owner;
    end
  end

  p_acquire_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!taken_q && sem_en && wr_sel && wr_bit && allow[cid]) |=> (taken_q && owner_q == $past(cid)));

  p_allow_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!taken_q && wr_sel && wr_bit && !allow[cid]) |=> !taken_q);

  p_taken_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_q && sem_en && wr_sel && wr_bit) |=> (taken_q && owner_q == $past(owner_q)));

  p_foreign_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_q && sem_en && wr_sel && owner_q != cid) |=> (taken_q && owner_q == $past(owner_q)));

  p_disable_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sem_en |=> !taken_q);

  p_free_owner_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_q |-> owner_q == '0);
endmodule

// File: rtl/semlock_rsp.sv
module semlock_rsp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              accept,
  input  logic [DATA_W-1:0] rd_word,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_accept_gives_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

// File: rtl/semlock_array.sv
module semlock_array
  import semlock_pkg::*;
#(
  parameter int N_RES  = 16,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [CID_W-1:0]         req_cid,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [DATA_W-1:0]        rsp_rdata,
  input  logic [N_RES-1:0]         cfg_sem_en,
  input  logic [NUM_CID*N_RES-1:0] cfg_cid_allow,
  output logic [N_RES-1:0]         sem_taken,
  output logic [CID_W*N_RES-1:0]   sem_owner
);
  localparam int IDX_W = (N_RES > 1) ? $clog2(N_RES) : 1;

  logic             dec_hit;
  logic [IDX_W-1:0] dec_idx;
  logic             accept;
  logic [DATA_W-1:0] rd_word;
  logic             nxt_taken [N_RES];
  logic [CID_W-1:0] nxt_owner [N_RES];
  logic             unused_wdata;

  assign unused_wdata = ^req_wdata[DATA_W-1:1];

  semlock_decode #(.ADDR_W(ADDR_W), .N_RES(N_RES), .IDX_W(IDX_W)) u_dec (
    .addr (req_addr),
    .hit  (dec_hit),
    .idx  (dec_idx)
  );

  for (genvar g = 0; g < N_RES; g++) begin : g_cell
    logic wr_sel;
    assign wr_sel = accept && req_write && dec_hit && (dec_idx == IDX_W'(g));
    semlock_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .sem_en    (cfg_sem_en[g]),
      .allow     (cfg_cid_allow[g*NUM_CID +: NUM_CID]),
      .wr_sel    (wr_sel),
      .wr_bit    (req_wdata[FLAG_BIT]),
      .cid       (req_cid),
      .taken_q   (sem_taken[g]),
      .owner_q   (sem_owner[g*CID_W +: CID_W]),
      .nxt_taken (nxt_taken[g]),
      .nxt_owner (nxt_owner[g])
    );
  end

  always_comb begin
    rd_word = '0;
    if (dec_hit) begin
      rd_word[FLAG_BIT]              = nxt_taken[dec_idx];
      rd_word[OWNER_LSB +: CID_W]    = nxt_owner[dec_idx];
    end
  end

  semlock_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .accept    (accept),
    .rd_word   (rd_word),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata)
  );

  p_unmapped_write_inert_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && !dec_hit && (&cfg_sem_en)) |=>
      (sem_taken == $past(sem_taken) && sem_owner == $past(sem_owner)));
endmodule

// File: tb/tb_semlock_array.sv
`timescale 1ns/1ps
module tb_semlock_array;
  localparam int N = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic req_ready, rsp_valid;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0, rsp_rdata;
  logic [2:0]  req_cid = '0;
  logic [N-1:0] cfg_en = '1;
  logic [8*N-1:0] cfg_wl = '1;
  logic [N-1:0] sem_taken;
  logic [3*N-1:0] sem_owner;

  always #10 clk = ~clk;

  semlock_array #(.N_RES(N), .ADDR_W(12), .DATA_W(32)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_cid(req_cid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .cfg_sem_en(cfg_en), .cfg_cid_allow(cfg_wl),
    .sem_taken(sem_taken), .sem_owner(sem_owner)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic       m_taken [N];
  logic [2:0] m_owner [N];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void free_disabled();
    for (int i = 0; i < N; i++)
      if (!cfg_en[i]) begin m_taken[i] = 0; m_owner[i] = 0; end
  endfunction

  function automatic logic [31:0] model_step(input bit wr, input logic [11:0] a,
                                             input logic [31:0] wd, input logic [2:0] cid);
    int off, idx;
    bit hit;
    free_disabled();
    off = int'(a) - 'h104;
    hit = (off >= 0) && (off % 8 == 0) && (off / 8 < N);
    if (!hit) return 32'h0;
    idx = off / 8;
    if (wr && cfg_en[idx]) begin
      if (wd[0] && !m_taken[idx] && cfg_wl[idx*8 + cid]) begin
        m_taken[idx] = 1; m_owner[idx] = cid;
      end else if (!wd[0] && m_taken[idx] && m_owner[idx] == cid) begin
        m_taken[idx] = 0; m_owner[idx] = 0;
      end
    end
    return {25'h0, m_owner[idx], 3'b000, m_taken[idx]};
  endfunction

  task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] wd,
                        input logic [2:0] cid, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd; req_cid = cid;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    exp_q.push_back(model_step(wr, a, wd, cid));
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    free_disabled();
    @(negedge clk);
  endtask

  task automatic check_state(input string tag);
    logic [N-1:0] et;
    logic [3*N-1:0] eo;
    for (int i = 0; i < N; i++) begin
      et[i] = m_taken[i];
      eo[i*3 +: 3] = m_owner[i];
    end
    chk(sem_taken == et, {tag, " taken"}, 64'(sem_taken), 64'(et));
    chk(sem_owner == eo, {tag, " owner"}, 64'(sem_owner), 64'(eo));
  endtask

  function automatic logic [11:0] sa(input int n);
    return 12'(('h104) + 8 * n);
  endfunction

  // Scoreboard monitor: compares each response at its handshake
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8 unexpected response", 64'(rsp_rdata), 64'h0);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rsp_rdata == e, t, 64'(rsp_rdata), 64'(e));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    for (int i = 0; i < N; i++) begin m_taken[i] = 0; m_owner[i] = 0; end
    repeat (3) @(negedge clk);
    chk(sem_taken == '0 && sem_owner == '0, "R1 reset state", 64'(sem_owner), 64'h0);
    chk(rsp_valid == 0, "R1 no response in reset", 64'(rsp_valid), 64'h0);
    rst_n = 1;
    @(negedge clk);

    access(0, sa(2), 0, 3, "R2 read free semaphore");
    access(1, sa(2), 32'h1, 3, "R3 claim by 3");
    check_state("R3 outputs after claim");
    access(1, sa(2), 32'h1, 5, "R5 claim on taken by other");
    access(1, sa(2), 32'hFFFF_FFFF, 3, "R5 claim on taken by holder");
    access(0, sa(2), 0, 6, "R9 readback holder 3");
    access(1, sa(2), 32'h0, 5, "R6 release by non-holder");
    check_state("R6 non-holder release inert");
    access(1, sa(2), 32'hFFFF_FFFE, 3, "R6 release by holder");
    check_state("R9 owner cleared when free");

    cfg_wl[4*8 +: 8] = 8'b0000_0100;
    access(1, sa(4), 32'h1, 1, "R4 claim not on allow list");
    check_state("R4 outputs after refused claim");
    access(1, sa(4), 32'h1, 2, "R3 claim on allow list");

    cfg_en[6] = 0;
    access(1, sa(6), 32'h1, 1, "R4 claim with mode off");
    cfg_en[6] = 1;

    access(1, sa(N-1), 32'hABCD_0001, 7, "R2 last semaphore claim");
    access(1, sa(0), 32'h1, 0, "R3 claim by ID 0");
    check_state("R9 outputs with several held");

    access(1, 12'h108, 32'h1, 1, "R2 write to config word no effect");
    access(1, sa(N), 32'h1, 1, "R2 write past last semaphore");
    check_state("R2 unmapped writes inert");
    access(0, 12'h100, 0, 1, "R2 read unmapped");
    access(0, sa(0) + 12'h4, 0, 1, "R2 read misaligned");

    // R7: mode off frees a held semaphore
    cfg_en[4] = 0;
    tick();
    check_state("R7 mode off frees");
    cfg_en[4] = 1;
    tick();
    // R7: mode off in the same cycle as a claim
    fork
      access(1, sa(4), 32'h1, 2, "R7 claim with same-cycle mode off");
      begin @(negedge clk); cfg_en[4] = 0; end
    join
    check_state("R7 same-cycle outputs");
    cfg_en[4] = 1;
    tick();

    // R8: stalled response holds data and blocks requests
    rsp_ready = 0;
    access(0, sa(N-1), 0, 0, "R8 stalled read data");
    chk(req_ready == 0, "R8 ready low while held", 64'(req_ready), 64'h0);
    held = rsp_rdata;
    @(negedge clk);
    chk(rsp_valid == 1 && rsp_rdata == held, "R8 held data stable",
        64'(rsp_rdata), 64'(held));
    rsp_ready = 1;
    @(negedge clk);
    access(0, sa(0), 0, 0, "R8 read after stall");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all responses returned", 64'(exp_q.size()), 64'h0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule